// File: doc/BRIEF.md
# Lock-Step SIMD Instruction Sequencer

This block is the one control unit shared by a group of lock-stepped compute lanes. It keeps a single program counter and a single 32-bit instruction register. It reads each instruction word from a synchronous program memory and cuts the word into an 8-bit opcode, a 14-bit address/immediate field and two 5-bit register fields. It then presents the opcode and the three fields to every lane in the same cycle, with one issue strobe. The lane datapaths, their register files and the data memory sit outside this block.

Control transfer is decided here. An unconditional jump loads its target from the 14-bit field. The two conditional jumps test a per-lane zero flag, which the lanes return for the register named in the 5-bit field. Because the lanes run one shared program, a conditional jump is taken only when every lane agrees. If any lane disagrees, the sequencer falls through to the next word. A stop instruction freezes the block until reset. A busy input from the store unit holds off the next fetch. Two counters, one for executed instructions and one for elapsed cycles, are brought out so that a test environment can measure a program run.

Top module: `simd_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the fetch address is 0, issue_valid is 0, halted is 0, and both counters read 0.
- R2: During the issue cycle, issue_op equals word bits [31:24], issue_a1 equals bits [23:10], issue_a2 equals bits [9:5] and issue_a3 equals bits [4:0] of the word read at the current fetch address.
- R3: Each instruction takes three cycles when the store unit is idle: a fetch cycle, a load cycle and an issue cycle. issue_valid is high for exactly the one issue cycle.
- R4: Opcode 0x20 (jump) makes the next fetch address equal to the low bits of issue_a1.
- R5: Opcode 0x21 (jump-if-zero) is taken to issue_a1 only when all lane_zero bits are 1. Otherwise the next address is the current address plus 1.
- R6: Opcode 0x22 (jump-if-nonzero) is taken to issue_a1 only when all lane_zero bits are 0. Otherwise the next address is the current address plus 1.
- R7: Opcode 0x30 with issue_a1 equal to 4 sets halted after its issue cycle. halted stays set until reset, and no further instruction is issued. Opcode 0x30 with any other issue_a1 value acts as a no-operation.
- R8: While store_busy is high during a fetch cycle, the fetch address is held and nothing is issued. The stall lasts one extra cycle for every such cycle.
- R9: Any opcode other than 0x20, 0x21, 0x22 and 0x30 is issued unchanged, and execution continues at the current address plus 1.
- R10: retired_count rises by one for each issued instruction, including the stop instruction. cycle_count rises by one on every cycle from reset until halted is set, and holds after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Program memory address (the program counter) |
| imem_rdata | input | 32 | Program memory word, one cycle after the address |
| lane_zero | input | LANES | Per-lane flag: the register named by issue_a2 is zero |
| store_busy | input | 1 | Store unit busy; holds the next fetch |
| issue_valid | output | 1 | Decoded instruction is presented to all lanes |
| issue_op | output | 8 | Opcode field |
| issue_a1 | output | 14 | Address / immediate / slot field |
| issue_a2 | output | 5 | First register field |
| issue_a3 | output | 5 | Second register field |
| halted | output | 1 | Stop instruction executed; sticky until reset |
| retired_count | output | CNT_W | Executed-instruction count |
| cycle_count | output | CNT_W | Cycles elapsed since reset until halt |

## Verification
The in-line assertions check on every cycle the rules that can be stated locally. These are: the sticky halt and the absence of issues after it, the held address during a busy stall, the jump target and the fall-through address of ordinary opcodes, and the one-step rise of the retired count and the frozen cycle count. The bench scenarios cover the rest. They check whether the lanes agree on a conditional branch, using all-zero, all-nonzero and mixed flag patterns. They check the order in which instructions are issued along a whole program, a stop code that is not 4, and the exact cycle total including the store stalls.

// File: rtl/simd_seq_pkg.sv
package simd_seq_pkg;
  localparam int INSN_W = 32;
  localparam int OP_W   = 8;
  localparam int A1_W   = 14;
  localparam int REG_W  = 5;

  localparam logic [OP_W-1:0] OP_JMP  = 8'h20;
  localparam logic [OP_W-1:0] OP_JZ   = 8'h21;
  localparam logic [OP_W-1:0] OP_JNZ  = 8'h22;
  localparam logic [OP_W-1:0] OP_SYS  = 8'h30;
  localparam logic [A1_W-1:0] SYS_STOP_CODE = 14'd4;

  typedef enum logic [1:0] {
    SQ_FETCH = 2'd0,
    SQ_LOAD  = 2'd1,
    SQ_ISSUE = 2'd2,
    SQ_HALT  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic jmp;
    logic jz;
    logic jnz;
    logic stop;
  } ctrl_class_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import simd_seq_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [A1_W-1:0] a1,
  output ctrl_class_t     cls
);
  always_comb begin
    cls      = '0;
    cls.jmp  = (op == OP_JMP);
    cls.jz   = (op == OP_JZ);
    cls.jnz  = (op == OP_JNZ);
    cls.stop = (op == OP_SYS) && (a1 == SYS_STOP_CODE);
  end
endmodule

// File: rtl/seq_lane_vote.sv
module seq_lane_vote #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] lane_zero,
  output logic             all_zero,
  output logic             all_nonzero
);
  logic [LANES:0] zero_chain;
  logic [LANES:0] nz_chain;

  assign zero_chain[0] = 1'b1;
  assign nz_chain[0]   = 1'b1;

  for (genvar g = 0; g < LANES; g++) begin : g_vote
    assign zero_chain[g+1] = zero_chain[g] & lane_zero[g];
    assign nz_chain[g+1]   = nz_chain[g] & ~lane_zero[g];
  end

  assign all_zero    = zero_chain[LANES];
  assign all_nonzero = nz_chain[LANES];
endmodule

// File: rtl/seq_perf_count.sv
module seq_perf_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             retire,
  output logic [CNT_W-1:0] cycles,
  output logic [CNT_W-1:0] retired
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cycles  <= '0;
      retired <= '0;
    end else begin
      if (run)    cycles  <= cycles + 1'b1;
      if (retire) retired <= retired + 1'b1;
    end
  end

  p_cycle_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cycles));
  p_retire_step_r10: assert property (@(posedge clk) disable iff (rst)
    retire |=> retired == $past(retired) + 1'b1);
endmodule

// File: rtl/simd_seq.sv
module simd_seq
  import simd_seq_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PC_W  = 14,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [PC_W-1:0]  imem_addr,
  input  logic [31:0]      imem_rdata,
  input  logic [LANES-1:0] lane_zero,
  input  logic             store_busy,
  output logic             issue_valid,
  output logic [7:0]       issue_op,
  output logic [13:0]      issue_a1,
  output logic [4:0]       issue_a2,
  output logic [4:0]       issue_a3,
  output logic             halted,
  output logic [CNT_W-1:0] retired_count,
  output logic [CNT_W-1:0] cycle_count
);
  localparam int A1_LSB = REG_W * 2;
  localparam int OP_LSB = A1_LSB + A1_W;

  seq_state_e        state;
  logic [PC_W-1:0]   pc;
  logic [INSN_W-1:0] ir;
  ctrl_class_t       cls;
  logic              all_zero;
  logic              all_nonzero;
  logic              take;
  logic [PC_W-1:0]   pc_next;

  assign issue_op    = ir[OP_LSB +: OP_W];
  assign issue_a1    = ir[A1_LSB +: A1_W];
  assign issue_a2    = ir[REG_W +: REG_W];
  assign issue_a3    = ir[0 +: REG_W];
  assign issue_valid = (state == SQ_ISSUE);
  assign halted      = (state == SQ_HALT);
  assign imem_addr   = pc;

  seq_decode u_decode (
    .op  (issue_op),
    .a1  (issue_a1),
    .cls (cls)
  );

  seq_lane_vote #(.LANES(LANES)) u_vote (
    .lane_zero   (lane_zero),
    .all_zero    (all_zero),
    .all_nonzero (all_nonzero)
  );

  always_comb begin
    take    = cls.jmp | (cls.jz & all_zero) | (cls.jnz & all_nonzero);
    pc_next = take ? PC_W'(issue_a1) : pc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_FETCH;
      pc    <= '0;
      ir    <= '0;
    end else begin
      case (state)
        SQ_FETCH: if (!store_busy) state <= SQ_LOAD;
        SQ_LOAD: begin
          ir    <= imem_rdata;
          state <= SQ_ISSUE;
        end
        SQ_ISSUE: begin
          if (cls.stop) begin
            state <= SQ_HALT;
          end else begin
            pc    <= pc_next;
            state <= SQ_FETCH;
          end
        end
        default: state <= SQ_HALT;
      endcase
    end
  end

  seq_perf_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .run     (!halted),
    .retire  (issue_valid),
    .cycles  (cycle_count),
    .retired (retired_count)
  );

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  p_no_issue_halted_r7: assert property (@(posedge clk) disable iff (rst)
    halted |-> !issue_valid);
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_FETCH && store_busy) |=> ($stable(imem_addr) && !issue_valid));
  p_jump_target_r4: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_op == OP_JMP) |=> imem_addr == PC_W'($past(issue_a1)));
  p_fall_through_r9: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_op != OP_JMP && issue_op != OP_JZ &&
     issue_op != OP_JNZ && issue_op != OP_SYS)
    |=> imem_addr == $past(imem_addr) + 1'b1);
endmodule

// File: tb/test_simd_seq.sv
module test_simd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int PC_W  = 14;
  localparam int CNT_W = 32;
  localparam int STALL_EXTRA = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [PC_W-1:0]  imem_addr;
  logic [31:0]      imem_rdata;
  logic [LANES-1:0] lane_zero;
  logic             store_busy = 1'b0;
  logic             issue_valid;
  logic [7:0]       issue_op;
  logic [13:0]      issue_a1;
  logic [4:0]       issue_a2;
  logic [4:0]       issue_a3;
  logic             halted;
  logic [CNT_W-1:0] retired_count;
  logic [CNT_W-1:0] cycle_count;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] prog [0:63];
  logic [3:0]  flags [0:63];
  logic [PC_W-1:0] exp_pc_q [$];
  logic [31:0]     exp_ir_q [$];
  int exp_n_insn = 0;
  int exp_n_store = 0;
  int busy_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_seq #(.LANES(LANES), .PC_W(PC_W), .CNT_W(CNT_W)) i_simd_seq (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .lane_zero(lane_zero), .store_busy(store_busy), .issue_valid(issue_valid),
    .issue_op(issue_op), .issue_a1(issue_a1), .issue_a2(issue_a2),
    .issue_a3(issue_a3), .halted(halted), .retired_count(retired_count),
    .cycle_count(cycle_count)
  );

  always_ff @(posedge clk) imem_rdata <= prog[imem_addr[5:0]];
  assign lane_zero = flags[imem_addr[5:0]];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv, input string what);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] op, input logic [13:0] a1,
                                     input logic [4:0] a2, input logic [4:0] a3);
    return {op, a1, a2, a3};
  endfunction

  task automatic put(input int at, input logic [31:0] w, input logic [3:0] f);
    prog[at]  = w;
    flags[at] = f;
  endtask

  // driver: walks the program by the requirement rules and queues expected issues
  task automatic build_expect();
    logic [PC_W-1:0] p;
    p = '0;
    for (int k = 0; k < 64; k++) begin
      logic [31:0] w;
      logic [7:0]  op;
      logic [13:0] a1;
      w  = prog[p[5:0]];
      op = w[31:24];
      a1 = w[23:10];
      exp_pc_q.push_back(p);
      exp_ir_q.push_back(w);
      exp_n_insn++;
      if (op == 8'h05) exp_n_store++;
      if (op == 8'h30 && a1 == 14'd4) break;
      if (op == 8'h20) p = PC_W'(a1);                                        // R4
      else if (op == 8'h21 && flags[p[5:0]] == 4'b1111) p = PC_W'(a1);      // R5
      else if (op == 8'h22 && flags[p[5:0]] == 4'b0000) p = PC_W'(a1);      // R6
      else p = p + 1'b1;                                                      // R9
    end
  endtask

  // store-unit model: an opcode 0x05 raises busy for a few cycles after issue
  always @(negedge clk) begin
    if (!rst && issue_valid && issue_op == 8'h05) busy_cnt = 4;
    store_busy = (busy_cnt > 0);
    if (busy_cnt > 0) busy_cnt--;
  end

  // monitor: pops expected items at each issue
  always @(negedge clk) begin
    if (!rst && issue_valid) begin
      if (exp_pc_q.size() == 0) begin
        check("R7", 64'd1, 64'd0, "issue after expected end");
      end else begin
        logic [PC_W-1:0] ep;
        logic [31:0] ew;
        ep = exp_pc_q.pop_front();
        ew = exp_ir_q.pop_front();
        check("R3", 64'(imem_addr), 64'(ep), "issue address");
        check("R2", 64'(issue_op), 64'(ew[31:24]), "op field");
        check("R2", 64'(issue_a1), 64'(ew[23:10]), "a1 field");
        check("R2", 64'(issue_a2), 64'(ew[9:5]), "a2 field");
        check("R2", 64'(issue_a3), 64'(ew[4:0]), "a3 field");
      end
    end
  end

  initial begin
    bit done;
    for (int i = 0; i < 64; i++) put(i, 32'h0, 4'b0000);
    put(0,  mk(8'h01, 14'd3, 5'd1, 5'd2), 4'b0000);
    put(1,  mk(8'h05, 14'd7, 5'd0, 5'd0), 4'b0000);
    put(2,  mk(8'h21, 14'd10, 5'd3, 5'd0), 4'b1111);   // R5 taken
    put(10, mk(8'h22, 14'd20, 5'd3, 5'd0), 4'b0000);   // R6 taken
    put(20, mk(8'h21, 14'd30, 5'd3, 5'd0), 4'b0111);   // R5 not taken
    put(21, mk(8'h22, 14'd30, 5'd3, 5'd0), 4'b0001);   // R6 not taken
    put(22, mk(8'hEE, 14'h2AA, 5'd17, 5'd9), 4'b1010); // R9 unknown
    put(23, mk(8'h30, 14'd3, 5'd0, 5'd0), 4'b0000);    // R7 non-stop code
    put(24, mk(8'h20, 14'd40, 5'd0, 5'd0), 4'b0000);   // R4
    put(40, mk(8'h05, 14'd9, 5'd2, 5'd1), 4'b0000);
    put(41, mk(8'h30, 14'd4, 5'd0, 5'd0), 4'b0000);    // R7 stop
    put(30, mk(8'h20, 14'd30, 5'd0, 5'd0), 4'b0000);   // trap if wrongly taken
    build_expect();

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 64'(imem_addr), 64'd0, "reset address");
    check("R1", 64'(issue_valid), 64'd0, "reset issue_valid");
    check("R1", 64'(halted), 64'd0, "reset halted");
    check("R1", 64'(retired_count), 64'd0, "reset retired");
    check("R1", 64'(cycle_count), 64'd0, "reset cycles");
    rst = 1'b0;

    done = 1'b0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (halted) begin done = 1'b1; break; end
    end
    if (!done) check("R7", 64'd0, 64'd1, "watchdog: halt not reached");

    check("R7", 64'(halted), 64'd1, "halted set");
    check("R3", 64'(exp_pc_q.size()), 64'd0, "all expected issues seen");
    check("R10", 64'(retired_count), 64'(exp_n_insn), "retired count");
    check("R8", 64'(cycle_count), 64'(3*exp_n_insn + STALL_EXTRA*exp_n_store), "cycle count with stalls");
    repeat (20) @(negedge clk);
    check("R7", 64'(halted), 64'd1, "halted sticky");
    check("R10", 64'(cycle_count), 64'(3*exp_n_insn + STALL_EXTRA*exp_n_store), "cycle count frozen");
    check("R10", 64'(retired_count), 64'(exp_n_insn), "retired frozen");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule